// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two byte-wide bidirectional ports, called A and B, through a pair of holding registers, one for each direction of travel. Each port is represented by three signals in place of a tri-state pin: an incoming data vector, an outgoing data vector and an enable that says whether the block is driving that port. A shared active-low enable and a direction select decide which port the block drives, if any. For the driven port, a per-direction select chooses between the live value on the opposite port and the value held in that direction's register.

The two registers have separate capture clocks. Each register samples its source port on every rising edge of its own clock, whatever the enable and direction inputs are set to. This means data can be stored while both ports are isolated, and a value can be captured from a port while the block is driving the other port. The data path from the inputs to the driven port contains no register stage, so a change on a select or on live data reaches the driven port without waiting for a clock edge.

Top module: `bus_xcvr_reg`

## Requirements
- R1: A high `rst` sampled on a rising edge of a capture clock clears that clock's register to zero, and reset takes priority over capture.
- R2: On each rising edge of `clk_ab` with `rst` low, the register for the A-to-B direction loads `a_in`. The B-to-A register is left unchanged.
- R3: On each rising edge of `clk_ba` with `rst` low, the register for the B-to-A direction loads `b_in`. The A-to-B register is left unchanged.
- R4: Capture into either register takes place for every setting of `oe_n`, `dir`, `sel_ab` and `sel_ba`, including the isolated state. Both registers can load in the same isolated period.
- R5: While `oe_n` is 1, both `a_oe` and `b_oe` are 0, and both `a_out` and `b_out` read all zeros.
- R6: While `oe_n` is 0 and `dir` is 1, `b_oe` is 1, `a_oe` is 0 and `a_out` reads zero.
- R7: While `oe_n` is 0 and `dir` is 0, `a_oe` is 1, `b_oe` is 0 and `b_out` reads zero.
- R8: While port B is driven, `b_out` equals `a_in` when `sel_ab` is 0, and equals the A-to-B register when `sel_ab` is 1.
- R9: While port A is driven, `a_out` equals `b_in` when `sel_ba` is 0, and equals the B-to-A register when `sel_ba` is 1.
- R10: `a_oe` and `b_oe` are never 1 at the same time.
- R11: The outputs are combinational functions of the controls, the live inputs and the register contents. An input change appears on the outputs in the same time step, without a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ab | input | 1 | Capture clock for the A-to-B register |
| clk_ba | input | 1 | Capture clock for the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, sampled by each capture clock |
| oe_n | input | 1 | Active-low output enable shared by both ports |
| dir | input | 1 | Selects the driven port: 1 drives B, 0 drives A |
| sel_ab | input | 1 | B-side source: 0 takes live A data, 1 takes the stored A-to-B value |
| sel_ba | input | 1 | A-side source: 0 takes live B data, 1 takes the stored B-to-A value |
| a_in | input | 8 | Data arriving on port A |
| b_in | input | 8 | Data arriving on port B |
| a_out | output | 8 | Data the block drives onto port A |
| a_oe | output | 1 | Port A drive enable |
| b_out | output | 8 | Data the block drives onto port B |
| b_oe | output | 1 | Port B drive enable |

## Verification
The routing and multiplexing results are due in the same time step as the stimulus. The bench therefore applies the controls and data, waits one nanosecond and then samples the outputs, with no capture-clock edge in between. A register result is due right after the rising edge of its own capture clock. The bench first produces that edge with a pulse task, then shows the stored value by setting the matching select and reading the driven port after the pulse has ended. Both clocks are kept low at every sampling point, so no sample falls on an edge.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;

    localparam int LANE_W = 8;

    typedef enum logic [1:0] {
        ROUTE_ISOLATE = 2'd0,
        ROUTE_TO_A    = 2'd1,
        ROUTE_TO_B    = 2'd2
    } route_e;

    typedef struct packed {
        logic drive_a;
        logic drive_b;
    } drive_t;

    function automatic route_e pick_route(input logic en_n, input logic to_b);
        if (en_n)      return ROUTE_ISOLATE;
        else if (to_b) return ROUTE_TO_B;
        else           return ROUTE_TO_A;
    endfunction

    function automatic drive_t route_enables(input route_e r);
        drive_t d;
        d.drive_a = (r == ROUTE_TO_A);
        d.drive_b = (r == ROUTE_TO_B);
        return d;
    endfunction

endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
    parameter int W = xcvr_pkg::LANE_W
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk) begin
        if (rst) q <= '0;
        else     q <= d;
    end

    AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (q == '0)); // R1
    AST_CAPTURE_EDGE: assert property (@(posedge clk) disable iff (rst)
                                       1'b1 |=> (q == $past(d))); // R2

endmodule

// File: rtl/xcvr_route.sv
module xcvr_route
    import xcvr_pkg::*;
(
    input  logic   oe_n,
    input  logic   dir,
    output drive_t drv
);

    route_e route;

    always_comb begin
        route = pick_route(oe_n, dir);
        drv   = route_enables(route);
    end

endmodule

// File: rtl/xcvr_pick.sv
module xcvr_pick #(
    parameter int W = xcvr_pkg::LANE_W
) (
    input  logic         en,
    input  logic         sel,
    input  logic [W-1:0] live,
    input  logic [W-1:0] held,
    output logic [W-1:0] y
);

    for (genvar i = 0; i < W; i++) begin : g_lane
        always_comb y[i] = en & (sel ? held[i] : live[i]);
    end

endmodule

// File: rtl/bus_xcvr_reg.sv
module bus_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int W = LANE_W
) (
    input  logic         clk_ab,
    input  logic         clk_ba,
    input  logic         rst,
    input  logic         oe_n,
    input  logic         dir,
    input  logic         sel_ab,
    input  logic         sel_ba,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output logic [W-1:0] a_out,
    output logic         a_oe,
    output logic [W-1:0] b_out,
    output logic         b_oe
);

    logic [W-1:0] ab_q;
    logic [W-1:0] ba_q;
    drive_t       drv;

    xcvr_store #(.W(W)) u_store_ab (.clk(clk_ab), .rst(rst), .d(a_in), .q(ab_q));
    xcvr_store #(.W(W)) u_store_ba (.clk(clk_ba), .rst(rst), .d(b_in), .q(ba_q));

    xcvr_route u_route (.oe_n(oe_n), .dir(dir), .drv(drv));

    xcvr_pick #(.W(W)) u_pick_b (.en(drv.drive_b), .sel(sel_ab),
                                 .live(a_in), .held(ab_q), .y(b_out));
    xcvr_pick #(.W(W)) u_pick_a (.en(drv.drive_a), .sel(sel_ba),
                                 .live(b_in), .held(ba_q), .y(a_out));

    always_comb begin
        a_oe = drv.drive_a;
        b_oe = drv.drive_b;
    end

    always_comb begin
        if (!$isunknown({a_oe, b_oe})) begin
            AST_ONE_DRIVER: assert (!(a_oe && b_oe)); // R10
        end
        if (!$isunknown({oe_n, a_oe, b_oe, a_out, b_out}) && oe_n) begin
            AST_ISOLATED: assert (!a_oe && !b_oe && a_out == '0 && b_out == '0); // R5
        end
        if (!$isunknown({b_oe, sel_ab, a_in, b_out}) && b_oe && !sel_ab) begin
            AST_B_LIVE: assert (b_out == a_in); // R8
        end
        if (!$isunknown({a_oe, sel_ba, ba_q, a_out}) && a_oe && sel_ba) begin
            AST_A_HELD: assert (a_out == ba_q); // R9
        end
    end

endmodule

// File: tb/bus_xcvr_reg_test.sv
module bus_xcvr_reg_test;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
    logic         oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
    logic [W-1:0] a_in = '0, b_in = '0;
    logic [W-1:0] a_out, b_out;
    logic         a_oe, b_oe;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    bus_xcvr_reg #(.W(W)) uut (
        .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
        .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .b_in(b_in),
        .a_out(a_out), .a_oe(a_oe), .b_out(b_out), .b_oe(b_oe)
    );

    always #2.5 clk = ~clk;

    // vector: oe_n dir sel_ab sel_ba a_in b_in | a_oe b_oe a_out b_out
    // stored values during the table: A-to-B = 8'h5A, B-to-A = 8'hC3
    localparam logic [37:0] VECS [8] = '{
        {4'b1000, 8'h11, 8'h22, 2'b00, 8'h00, 8'h00},  // R5
        {4'b1111, 8'h33, 8'h44, 2'b00, 8'h00, 8'h00},  // R5
        {4'b0000, 8'h11, 8'h22, 2'b10, 8'h22, 8'h00},  // R7 R9 live
        {4'b0001, 8'h11, 8'h22, 2'b10, 8'hC3, 8'h00},  // R7 R9 stored
        {4'b0100, 8'h66, 8'h22, 2'b01, 8'h00, 8'h66},  // R6 R8 live
        {4'b0110, 8'h66, 8'h22, 2'b01, 8'h00, 8'h5A},  // R6 R8 stored
        {4'b0111, 8'h77, 8'h88, 2'b01, 8'h00, 8'h5A},  // R6 R8 stored
        {4'b0010, 8'h11, 8'h99, 2'b10, 8'h99, 8'h00}   // R7 R9 live
    };

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic pulse(input bit do_ab, input bit do_ba);
        #1;
        if (do_ab) clk_ab = 1'b1;
        if (do_ba) clk_ba = 1'b1;
        #2;
        clk_ab = 1'b0;
        clk_ba = 1'b0;
        #2;
    endtask

    task automatic set_ctl(input logic n, input logic d, input logic sab, input logic sba);
        oe_n = n; dir = d; sel_ab = sab; sel_ba = sba;
    endtask

    initial begin
        while (!done) begin
            @(posedge clk);
            cycles++;
            if (cycles > 20000) begin
                checks++;
                errors++;
                $display("FAIL watchdog: actual=%0d expected=<20000", cycles);
                done = 1'b1;
            end
        end
    end

    initial begin
        // R1: reset both registers, then read them back as stored data
        rst = 1'b1;
        a_in = 8'hFF; b_in = 8'hFF;
        pulse(1'b1, 1'b1);
        rst = 1'b0;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0); #1;
        chk("R1 A-to-B reset", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
        chk("R1 B-to-A reset", a_out, 8'h00);

        // R4: capture into both registers together while isolated
        set_ctl(1'b1, 1'b0, 1'b0, 1'b0);
        a_in = 8'h5A; b_in = 8'hC3;
        pulse(1'b1, 1'b1);
        chk("R4 isolated outputs", {6'b0, a_oe, b_oe}, 8'h00);
        a_in = 8'h00; b_in = 8'h00;
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0); #1;
        chk("R4 stored A-to-B", b_out, 8'h5A);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
        chk("R4 stored B-to-A", a_out, 8'hC3);

        // table walk covering R5..R9
        foreach (VECS[i]) begin
            {oe_n, dir, sel_ab, sel_ba, a_in, b_in} = VECS[i][37:18];
            #1;
            chk("R5-R7 enables", {6'b0, a_oe, b_oe}, {6'b0, VECS[i][17:16]});
            chk("R9 a_out", a_out, VECS[i][15:8]);
            chk("R8 b_out", b_out, VECS[i][7:0]);
            chk("R10 one driver", {7'b0, a_oe & b_oe}, 8'h00);
            #1;
        end

        // R2: capture from A while driving B, B-to-A untouched
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0);
        a_in = 8'hE7; b_in = 8'h3C;
        pulse(1'b1, 1'b0);
        chk("R2 new A-to-B value", b_out, 8'hE7);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
        chk("R2 B-to-A kept", a_out, 8'hC3);

        // R3: capture from B alone, A-to-B untouched
        b_in = 8'h81; a_in = 8'h00;
        pulse(1'b0, 1'b1);
        chk("R3 new B-to-A value", a_out, 8'h81);
        set_ctl(1'b0, 1'b1, 1'b1, 1'b0); #1;
        chk("R3 A-to-B kept", b_out, 8'hE7);

        // R11: live changes show without any clock edge
        set_ctl(1'b0, 1'b1, 1'b0, 1'b0);
        a_in = 8'h12; #1;
        chk("R11 live to B", b_out, 8'h12);
        a_in = 8'hED; #1;
        chk("R11 live change", b_out, 8'hED);
        sel_ab = 1'b1; #1;
        chk("R11 select flip", b_out, 8'hE7);

        // R1: reset has priority over capture
        rst = 1'b1; a_in = 8'hAA; b_in = 8'h55;
        pulse(1'b1, 1'b0);
        rst = 1'b0; #1;
        chk("R1 reset over capture", b_out, 8'h00);
        set_ctl(1'b0, 1'b0, 1'b0, 1'b1); #1;
        chk("R1 B-to-A untouched by A clock", a_out, 8'h81);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule